// File: doc/BRIEF.md
# Signed Integer to Single-Precision Converter

This block turns a signed two's-complement integer, 32 or 64 bits wide, into an IEEE-754 binary32 value. The result goes in the low lane of a 128-bit vector result. The remaining 96 bits are built according to the form of the operation. In the legacy form they carry the previous destination contents. In the merge and masked forms they are copied from a first vector source.

The rounding mode normally comes from a persistent control field. A per-operation override replaces it, but only for register-sourced operations. A precision (inexact) flag is raised whenever rounding changed the value.

Inputs are accepted with a valid strobe. The registered result and flag appear, with a valid strobe, on the following clock cycle.

Top module: `int2sp_conv`

## Requirements
- R1: When `wide` is 0, only `src_int[31:0]` is read, as a signed 32-bit value, and bits [63:32] have no effect. When `wide` is 1, all 64 bits are read as a signed value.
- R2: `result[31:0]` is binary32 with the sign in bit 31, an exponent biased by 127 in bits [30:23] and the fraction in bits [22:0]. Integers whose magnitude fits in 24 significant bits convert exactly.
- R3: The active rounding code selects the mode: 00 is nearest with ties to even, 01 is toward negative infinity, 10 is toward positive infinity and 11 is toward zero. A rounding carry-out raises the exponent by one.
- R4: The active rounding code is `ovr_rnd` when `ovr_en` is 1 and `src_is_reg` is 1. In every other case it is `ctl_rnd`, so a memory-sourced operation ignores the override.
- R5: For `form` 00 (legacy), `result[127:32]` equals `prev_dst[127:32]`. For `form` 01, 10 or 11, it equals `vec_src1[127:32]`.
- R6: For `form` 10 (masked) with `wmask` 0, `result[31:0]` equals `prev_dst[31:0]` and `inexact` is 0. With `wmask` 1, the converted value is written.
- R7: `inexact` is 1 exactly when the written rounded value differs from the integer.
- R8: An input of zero gives +0.0 (all zero) without `inexact`. The most negative integer of either width converts exactly: 0xCF000000 for 32 bits and 0xDF000000 for 64 bits.
- R9: `out_valid` is `in_valid` delayed by one clock. Results appear in that same cycle, and `result` and `inexact` hold their values while no valid input arrives.
- R10: While `rst` is high, `out_valid`, `result` and `inexact` are cleared to zero on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| src_int | input | 64 | Integer operand |
| wide | input | 1 | 1 = 64-bit operand, 0 = low 32 bits |
| form | input | 2 | 00 legacy, 01 merge, 10 masked, 11 merge |
| src_is_reg | input | 1 | Operand comes from a register |
| vec_src1 | input | 128 | First vector source for merge forms |
| prev_dst | input | 128 | Current destination contents |
| ctl_rnd | input | 2 | Persistent rounding control field |
| ovr_en | input | 1 | Per-operation rounding override enable |
| ovr_rnd | input | 2 | Per-operation rounding code |
| wmask | input | 1 | Write-mask bit for the low lane |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 128 | Assembled vector result |
| inexact | output | 1 | Precision flag |

## Verification
The bench feeds operands just past 2^24: odd values, exact ties and their negatives. A converter with a wrong rounding-mode decode, or one that ignores the lsb in ties, produces a fraction off by one ulp there. The all-ones positive 64-bit value forces a rounding carry into the exponent; missing that carry wraps the fraction to zero without bumping the exponent, giving half the correct value. The most negative integers of both widths are also driven, and a faulty absolute value turns them into garbage. Narrow operands come with noisy upper bits, and the override is tried with memory-sourced operands and with masked-off lanes, so a leak of upper bits, override or flag into the result is visible.

// File: rtl/int2sp_pkg.sv
package int2sp_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_DOWN    = 2'b01,
    RM_UP      = 2'b10,
    RM_ZERO    = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    FORM_LEGACY = 2'b00,
    FORM_MERGE  = 2'b01,
    FORM_MASKED = 2'b10,
    FORM_MERGE2 = 2'b11
  } form_e;
endpackage

// File: rtl/int2sp_norm.sv
module int2sp_norm #(
  parameter int INT_W  = 64,
  parameter int HALF_W = 32,
  localparam int LZ_W  = $clog2(INT_W) + 1
) (
  input  logic [INT_W-1:0] src,
  input  logic             wide,
  output logic             sign,
  output logic             zero,
  output logic [INT_W-1:0] norm,
  output logic [LZ_W-1:0]  lz
);
  logic [INT_W-1:0] ext;
  logic [INT_W-1:0] mag;

  always_comb begin
    ext  = wide ? src : {{(INT_W-HALF_W){src[HALF_W-1]}}, src[HALF_W-1:0]};
    sign = ext[INT_W-1];
    mag  = sign ? (~ext + 1'b1) : ext;
    zero = (mag == '0);
    lz   = LZ_W'(INT_W);
    for (int i = 0; i < INT_W; i++) begin
      if (mag[i]) lz = LZ_W'(INT_W - 1 - i);
    end
    norm = mag << lz;
  end
endmodule

// File: rtl/int2sp_round.sv
module int2sp_round
  import int2sp_pkg::*;
#(
  parameter int INT_W = 64,
  parameter int MAN_W = 23,
  parameter int EXP_W = 8,
  parameter int BIAS  = 127,
  localparam int LZ_W  = $clog2(INT_W) + 1,
  localparam int SIG_W = MAN_W + 1,
  localparam int DROP_W = INT_W - SIG_W,
  localparam int FP_W  = 1 + EXP_W + MAN_W
) (
  input  logic             sign,
  input  logic             zero,
  input  logic [INT_W-1:0] norm,
  input  logic [LZ_W-1:0]  lz,
  input  rmode_e           rmode,
  output logic [FP_W-1:0]  word,
  output logic             inexact
);
  logic [SIG_W-1:0] sig;
  logic             g, r, s, lost, inc;
  logic [SIG_W:0]   sum;
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] frac;

  always_comb begin
    sig  = norm[INT_W-1 -: SIG_W];
    g    = norm[DROP_W-1];
    r    = norm[DROP_W-2];
    s    = |norm[DROP_W-3:0];
    lost = g | r | s;
    unique case (rmode)
      RM_NEAREST: inc = g & (r | s | sig[0]);
      RM_DOWN:    inc = sign & lost;
      RM_UP:      inc = ~sign & lost;
      default:    inc = 1'b0;
    endcase
    sum  = {1'b0, sig} + (SIG_W+1)'(inc);
    expo = EXP_W'(BIAS + INT_W - 1) - EXP_W'(lz) + EXP_W'(sum[SIG_W]);
    frac = sum[SIG_W] ? '0 : sum[MAN_W-1:0];
    if (zero) begin
      word    = '0;
      inexact = 1'b0;
    end else begin
      word    = {sign, expo, frac};
      inexact = lost;
    end
  end

  // R2: a nonzero integer never yields a magnitude below 1.0
  always_comb begin
    if (!zero) begin
      p_exp_floor_r2: assert (word[FP_W-2 -: EXP_W] >= EXP_W'(BIAS));
    end
  end
endmodule

// File: rtl/int2sp_lane.sv
module int2sp_lane
  import int2sp_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 32
) (
  input  form_e             form,
  input  logic              wmask,
  input  logic [LANE_W-1:0] conv,
  input  logic              conv_inexact,
  input  logic [VEC_W-1:0]  vec_src1,
  input  logic [VEC_W-1:0]  prev_dst,
  output logic [VEC_W-1:0]  res,
  output logic              inexact
);
  logic write_lo;

  always_comb begin
    write_lo = (form != FORM_MASKED) || wmask;
    if (form == FORM_LEGACY) res[VEC_W-1:LANE_W] = prev_dst[VEC_W-1:LANE_W];
    else                     res[VEC_W-1:LANE_W] = vec_src1[VEC_W-1:LANE_W];
    res[LANE_W-1:0] = write_lo ? conv : prev_dst[LANE_W-1:0];
    inexact         = write_lo & conv_inexact;
  end
endmodule

// File: rtl/int2sp_conv.sv
module int2sp_conv
  import int2sp_pkg::*;
#(
  parameter int INT_W  = 64,
  parameter int HALF_W = 32,
  parameter int VEC_W  = 128,
  parameter int MAN_W  = 23,
  parameter int EXP_W  = 8,
  parameter int BIAS   = 127,
  localparam int LZ_W   = $clog2(INT_W) + 1,
  localparam int LANE_W = 1 + EXP_W + MAN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [INT_W-1:0] src_int,
  input  logic             wide,
  input  logic [1:0]       form,
  input  logic             src_is_reg,
  input  logic [VEC_W-1:0] vec_src1,
  input  logic [VEC_W-1:0] prev_dst,
  input  logic [1:0]       ctl_rnd,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_rnd,
  input  logic             wmask,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             inexact
);
  rmode_e            rmode;
  logic              n_sign, n_zero;
  logic [INT_W-1:0]  n_norm;
  logic [LZ_W-1:0]   n_lz;
  logic [LANE_W-1:0] c_word;
  logic              c_inex;
  logic [VEC_W-1:0]  l_res;
  logic              l_inex;

  assign rmode = rmode_e'((ovr_en && src_is_reg) ? ovr_rnd : ctl_rnd);

  int2sp_norm #(.INT_W(INT_W), .HALF_W(HALF_W)) u_norm (
    .src(src_int), .wide(wide), .sign(n_sign), .zero(n_zero),
    .norm(n_norm), .lz(n_lz)
  );

  int2sp_round #(.INT_W(INT_W), .MAN_W(MAN_W), .EXP_W(EXP_W), .BIAS(BIAS)) u_round (
    .sign(n_sign), .zero(n_zero), .norm(n_norm), .lz(n_lz), .rmode(rmode),
    .word(c_word), .inexact(c_inex)
  );

  int2sp_lane #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_lane (
    .form(form_e'(form)), .wmask(wmask), .conv(c_word), .conv_inexact(c_inex),
    .vec_src1(vec_src1), .prev_dst(prev_dst), .res(l_res), .inexact(l_inex)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      inexact   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= l_res;
        inexact <= l_inex;
      end
    end
  end

  p_valid_lat_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(inexact)));
  p_legacy_upper_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form == 2'b00) |=> result[VEC_W-1:LANE_W] == $past(prev_dst[VEC_W-1:LANE_W]));
  p_merge_upper_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form != 2'b00) |=> result[VEC_W-1:LANE_W] == $past(vec_src1[VEC_W-1:LANE_W]));
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form == 2'b10 && !wmask) |=> (result[LANE_W-1:0] == $past(prev_dst[LANE_W-1:0]) && !inexact));
  p_zero_exact_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form != 2'b10 && wide && src_int == '0) |=> (result[LANE_W-1:0] == '0 && !inexact));
endmodule

// File: tb/tb_int2sp_conv.sv
`timescale 1ns/1ps
module tb_int2sp_conv;
  logic         clk = 0;
  logic         rst;
  logic         in_valid;
  logic [63:0]  src_int;
  logic         wide;
  logic [1:0]   form;
  logic         src_is_reg;
  logic [127:0] vec_src1, prev_dst;
  logic [1:0]   ctl_rnd, ovr_rnd;
  logic         ovr_en, wmask;
  logic         out_valid;
  logic [127:0] result;
  logic         inexact;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  int2sp_conv dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_int(src_int), .wide(wide),
    .form(form), .src_is_reg(src_is_reg), .vec_src1(vec_src1), .prev_dst(prev_dst),
    .ctl_rnd(ctl_rnd), .ovr_en(ovr_en), .ovr_rnd(ovr_rnd), .wmask(wmask),
    .out_valid(out_valid), .result(result), .inexact(inexact)
  );

  function automatic logic [31:0] ref_conv(input logic [63:0] s, input bit w,
                                           input logic [1:0] rm, output bit inx);
    logic [63:0] v, mag, q, rem, half;
    int p, drop;
    bit neg, up;
    v   = w ? s : {{32{s[31]}}, s[31:0]};
    neg = v[63];
    mag = neg ? (64'd0 - v) : v;
    inx = 0;
    if (mag == 0) return 32'd0;
    p = 0;
    for (int i = 0; i < 64; i++) if (mag[i]) p = i;
    if (p <= 23) q = mag << (23 - p);
    else begin
      drop = p - 23;
      q    = mag >> drop;
      rem  = mag & ((64'd1 << drop) - 64'd1);
      half = 64'd1 << (drop - 1);
      inx  = (rem != 0);
      case (rm)
        2'b00:   up = (rem > half) || (rem == half && q[0]);
        2'b01:   up = neg && inx;
        2'b10:   up = !neg && inx;
        default: up = 0;
      endcase
      if (up) q = q + 64'd1;
      if (q[24]) begin q = q >> 1; p++; end
    end
    return {neg, 8'(p + 127), q[22:0]};
  endfunction

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic op(input logic [63:0] s, input bit w, input logic [1:0] f, input bit isreg,
                    input logic [127:0] v1, input logic [127:0] pd, input logic [1:0] crm,
                    input bit oen, input logic [1:0] orm, input bit wm,
                    input string req, input bit use_want, input logic [31:0] want);
    logic [1:0] rm;
    logic [31:0] cv;
    logic [127:0] exp_res;
    bit cinx, exp_inx, wr;
    @(negedge clk);
    in_valid = 1; src_int = s; wide = w; form = f; src_is_reg = isreg;
    vec_src1 = v1; prev_dst = pd; ctl_rnd = crm; ovr_en = oen; ovr_rnd = orm; wmask = wm;
    rm = (oen && isreg) ? orm : crm;
    cv = ref_conv(s, w, rm, cinx);
    wr = (f != 2'b10) || wm;
    exp_res[127:32] = (f == 2'b00) ? pd[127:32] : v1[127:32];
    exp_res[31:0]   = wr ? cv : pd[31:0];
    exp_inx         = wr && cinx;
    @(negedge clk);
    chk({req, " valid"}, {127'd0, out_valid}, 128'd1);
    chk({req, " result"}, result, exp_res);
    chk({req, " inexact"}, {127'd0, inexact}, {127'd0, exp_inx});
    if (use_want) chk({req, " literal"}, result[31:0], {96'd0, want});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] hold;
    int seed;
    rst = 1; in_valid = 0; src_int = '1; wide = 1; form = 0; src_is_reg = 0;
    vec_src1 = '1; prev_dst = '1; ctl_rnd = 0; ovr_en = 0; ovr_rnd = 0; wmask = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 out_valid", {127'd0, out_valid}, 128'd0);
    chk("R10 result", result, 128'd0);
    chk("R10 inexact", {127'd0, inexact}, 128'd0);
    rst = 0;

    // R8 zero and most negative
    op(64'd0, 1, 2'b01, 1, {4{32'hA5A5_0F0F}}, '0, 2'b00, 0, 0, 0, "R8 zero", 1, 32'h0);
    op(64'h8000_0000_0000_0000, 1, 2'b01, 1, '0, '0, 2'b00, 0, 0, 0, "R8 min64", 1, 32'hDF00_0000);
    // R1 narrow read ignores upper bits
    op(64'hDEAD_BEEF_8000_0000, 0, 2'b01, 1, '0, '0, 2'b00, 0, 0, 0, "R1 R8 min32", 1, 32'hCF00_0000);
    op(64'hFFFF_FFFF_0000_0005, 0, 2'b01, 1, '0, '0, 2'b00, 0, 0, 0, "R1 five", 1, 32'h40A0_0000);
    op(64'h0000_0000_0000_0005, 1, 2'b01, 1, '0, '0, 2'b00, 0, 0, 0, "R2 five", 1, 32'h40A0_0000);
    // R3 R7 rounding modes just past 2^24
    op(64'd16777217, 1, 2'b01, 1, '0, '0, 2'b00, 0, 0, 0, "R3 R7 rne", 1, 32'h4B80_0000);
    op(64'd16777217, 1, 2'b01, 1, '0, '0, 2'b10, 0, 0, 0, "R3 up", 1, 32'h4B80_0001);
    op(64'd16777217, 1, 2'b01, 1, '0, '0, 2'b11, 0, 0, 0, "R3 zero", 1, 32'h4B80_0000);
    op(-64'sd16777217, 1, 2'b01, 1, '0, '0, 2'b01, 0, 0, 0, "R3 down", 1, 32'hCB80_0001);
    op(64'd16777219, 1, 2'b01, 1, '0, '0, 2'b00, 0, 0, 0, "R3 tie even", 1, 32'h4B80_0002);
    op(64'h7FFF_FFFF_FFFF_FFFF, 1, 2'b01, 1, '0, '0, 2'b00, 0, 0, 0, "R3 carry", 1, 32'h5F00_0000);
    op(64'd16777216, 1, 2'b01, 1, '0, '0, 2'b10, 0, 0, 0, "R7 exact", 1, 32'h4B80_0000);
    // R4 override only for register source
    op(64'd16777217, 1, 2'b01, 1, '0, '0, 2'b11, 1, 2'b10, 0, "R4 reg ovr", 1, 32'h4B80_0001);
    op(64'd16777217, 1, 2'b01, 0, '0, '0, 2'b11, 1, 2'b10, 0, "R4 mem ovr", 1, 32'h4B80_0000);
    // R5 R6 forms
    op(64'd3, 1, 2'b00, 1, {4{32'h1111_1111}}, {4{32'h2222_2222}}, 2'b00, 0, 0, 0, "R5 legacy", 0, 0);
    op(64'd3, 1, 2'b11, 1, {4{32'h1111_1111}}, {4{32'h2222_2222}}, 2'b00, 0, 0, 0, "R5 merge", 0, 0);
    op(64'd16777217, 1, 2'b10, 1, {4{32'h1111_1111}}, {4{32'h2222_2222}}, 2'b10, 0, 0, 0, "R6 masked off", 1, 32'h2222_2222);
    op(64'd16777217, 1, 2'b10, 1, {4{32'h1111_1111}}, {4{32'h2222_2222}}, 2'b10, 0, 0, 1, "R6 masked on", 1, 32'h4B80_0001);

    // R9 hold while idle
    @(negedge clk);
    hold = result;
    in_valid = 0; src_int = 64'h1234; prev_dst = '0; vec_src1 = '0; form = 2'b01;
    @(negedge clk);
    chk("R9 idle valid", {127'd0, out_valid}, 128'd0);
    chk("R9 idle result", result, hold);

    // random mix
    seed = 32'd2024;
    void'($urandom(seed));
    for (int n = 0; n < 400; n++) begin
      logic [63:0] s;
      s = {$urandom, $urandom};
      if (n % 3 == 1) s = s >> ($urandom % 64);
      if (n % 5 == 2) s = -s;
      op(s, 1'($urandom), 2'($urandom), 1'($urandom), {$urandom, $urandom, $urandom, $urandom},
         {$urandom, $urandom, $urandom, $urandom}, 2'($urandom), 1'($urandom), 2'($urandom),
         1'($urandom), "R1 R2 R3 R4 R5 R6 R7 random", 0, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule